// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, from the destination field of each incoming frame, whether the frame should be kept. It watches a byte stream and collects the first six bytes. When the sixth byte arrives it compares them against four programmable station addresses and the broadcast address. It then registers an accept/reject decision and a one-hot status word that names the rule that matched.

A second verdict is formed when the frame ends. The receiver reports the total frame length, and the block combines that length with the address decision. Oversize and undersize frames are refused according to the jumbo and big-frame settings. Both results stay stable until the next frame starts.

Each station address is loaded through a small write port, one 32-bit word and one 16-bit half at a time. A slot becomes usable only once its high half has been written. Writing its low word takes it out of service again, so software can update a slot without ever leaving a half-written address live.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every address slot is out of service, and `addr_ready`, `verdict_valid`, `accept` and `match_status` are all zero.
- R2: A slot matches when its low word equals frame bytes 0..3 and its high half equals bytes 4..5. Byte 0 is the most significant byte of the low word, and byte 4 is the most significant byte of the high half. `reg_sel[2:1]` selects the slot (0..3). `reg_sel[0]`=0 writes the low word from `reg_wdata[31:0]`, and `reg_sel[0]`=1 writes the high half from `reg_wdata[15:0]`.
- R3: Writing a slot's high half puts it in service, and writing its low word takes it out of service. A slot out of service never matches.
- R4: When several slots match, slot 0 wins over 1, 1 over 2, and 2 over 3. A match sets `match_status` bit 26, 25, 24 or 23 for slot 0, 1, 2 or 3, and `match_status` has at most one bit set.
- R5: The address FF:FF:FF:FF:FF:FF is accepted as broadcast with `match_status` bit 31 only when `cfg_no_bcast` is 0. A slot match takes precedence over broadcast.
- R6: When no rule matches, `match_status` is zero and the address decision accepts the frame only if `cfg_copy_all` is 1.
- R7: `addr_ready` rises in the cycle after the sixth byte is taken. From then on, `accept` and `match_status` hold until the next start-of-frame byte, apart from the end-of-frame verdict update.
- R8: `verdict_valid` rises in the cycle after `frm_end`. A frame length below 6 or above 10240 always gives `accept`=0.
- R9: A length above 1536 is rejected unless `cfg_jumbo`=1, and a length above 1518 is rejected unless `cfg_big`=1.
- R10: A frame that ends before its sixth byte is rejected, whatever length is reported.
- R11: While no decision exists, `accept` is 0. Once the verdict is valid, `accept` is the address decision ANDed with the length check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Address slot write strobe |
| reg_sel | input | 3 | Slot index in [2:1], half select in [0] |
| reg_wdata | input | 32 | Write data |
| byte_vld | input | 1 | A received byte is present |
| byte_sof | input | 1 | Marks the byte as byte 0 of a frame |
| byte_data | input | 8 | Received byte |
| frm_end | input | 1 | End-of-frame pulse, after the last byte |
| frm_len | input | 14 | Frame length in bytes, valid with `frm_end` |
| cfg_no_bcast | input | 1 | Refuse broadcast frames |
| cfg_copy_all | input | 1 | Accept frames whose address matches nothing |
| cfg_jumbo | input | 1 | Allow frames above 1536 bytes |
| cfg_big | input | 1 | Allow frames above 1518 bytes |
| addr_ready | output | 1 | Address decision available |
| verdict_valid | output | 1 | End-of-frame verdict available |
| accept | output | 1 | Keep the frame |
| match_status | output | 32 | One-hot code of the rule that matched |

## Verification
The hardest situation to reach from the ports is one where several service slots hold the same address and are then removed one at a time by low-word writes. Only this sequence shows that the priority order and the in-service bits interact correctly. The stimulus loads three slots with one address and sends that address after each successive low-word write, expecting the status bit to move from 25 to 24 to 23 and then to zero. It then re-arms the last slot with a lone high-half write. Length boundaries are driven at exactly 1518/1519, 1536/1537, 10240/10241 and 5 bytes, with the mode bits set so that each limit is tested on its own.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int NSLOT        = 4,
  parameter int LEN_W        = 14,
  parameter int MIN_LEN      = 6,
  parameter int MAX_LEN      = 10240,
  parameter int JUMBO_LEN    = 1536,
  parameter int BIG_LEN      = 1518,
  parameter int SLOT_BIT_TOP = 26,
  parameter int BCAST_BIT    = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [$clog2(NSLOT):0]   reg_sel,
  input  logic [31:0]              reg_wdata,
  input  logic                     byte_vld,
  input  logic                     byte_sof,
  input  logic [7:0]               byte_data,
  input  logic                     frm_end,
  input  logic [LEN_W-1:0]         frm_len,
  input  logic                     cfg_no_bcast,
  input  logic                     cfg_copy_all,
  input  logic                     cfg_jumbo,
  input  logic                     cfg_big,
  output logic                     addr_ready,
  output logic                     verdict_valid,
  output logic                     accept,
  output logic [31:0]              match_status
);
  localparam int IDX_W    = $clog2(NSLOT);
  localparam int DA_BYTES = 6;
  localparam logic [2:0] CNT_LAST = 3'(DA_BYTES - 1);
  localparam logic [2:0] CNT_DONE = 3'(DA_BYTES);
  localparam logic [2:0] CNT_IDLE = 3'd7;

  logic [2:0]       cnt;
  logic [39:0]      shreg;
  logic [47:0]      cand;
  logic [NSLOT-1:0] hit;
  logic [31:0]      code;
  logic             addr_acc, fin_acc, len_ok;

  wire start = byte_vld & byte_sof;
  wire sixth = byte_vld & ~byte_sof & (cnt == CNT_LAST);

  assign cand = {shreg, byte_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= CNT_IDLE;
      shreg <= '0;
    end else if (start) begin
      cnt   <= 3'd1;
      shreg <= {32'b0, byte_data};
    end else if (byte_vld && cnt < CNT_DONE) begin
      cnt   <= cnt + 3'd1;
      shreg <= {shreg[31:0], byte_data};
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [31:0] lo;
    logic [15:0] hi;
    logic        ok;
    wire sel = reg_we && (reg_sel[IDX_W:1] == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo <= '0;
        hi <= '0;
        ok <= 1'b0;
      end else if (sel) begin
        if (reg_sel[0]) begin
          hi <= reg_wdata[15:0];
          ok <= 1'b1;
        end else begin
          lo <= reg_wdata;
          ok <= 1'b0;
        end
      end
    end
    assign hit[i] = ok && (cand == {lo, hi});
  end

  always_comb begin
    code = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (hit[i]) code = 32'(1) << 5'(SLOT_BIT_TOP - i);
    if (code == '0 && !cfg_no_bcast && (&cand))
      code[BCAST_BIT] = 1'b1;
  end

  assign len_ok = (frm_len >= LEN_W'(MIN_LEN)) && (frm_len <= LEN_W'(MAX_LEN)) &&
                  (cfg_jumbo || frm_len <= LEN_W'(JUMBO_LEN)) &&
                  (cfg_big   || frm_len <= LEN_W'(BIG_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      addr_ready    <= 1'b0;
      addr_acc      <= 1'b0;
      match_status  <= '0;
      verdict_valid <= 1'b0;
      fin_acc       <= 1'b0;
    end else begin
      if (sixth) begin
        addr_ready   <= 1'b1;
        match_status <= code;
        addr_acc     <= (code != '0) | cfg_copy_all;
      end
      if (frm_end && !verdict_valid) begin
        verdict_valid <= 1'b1;
        fin_acc       <= addr_ready & addr_acc & len_ok;
      end
    end
  end

  assign accept = verdict_valid ? fin_acc : (addr_ready & addr_acc);
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk #(
  parameter int LEN_W     = 14,
  parameter int MIN_LEN   = 6,
  parameter int MAX_LEN   = 10240,
  parameter int JUMBO_LEN = 1536,
  parameter int BIG_LEN   = 1518
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             byte_sof,
  input logic             frm_end,
  input logic [LEN_W-1:0] frm_len,
  input logic             cfg_no_bcast,
  input logic             cfg_copy_all,
  input logic             cfg_jumbo,
  input logic             cfg_big,
  input logic             addr_ready,
  input logic             verdict_valid,
  input logic             accept,
  input logic [31:0]      match_status
);
  assert_onehot_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_status));

  assert_bcast_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ready) && match_status[31] |-> !$past(cfg_no_bcast));

  assert_copy_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ready) && match_status == 32'd0 |-> accept == $past(cfg_copy_all));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ready && !(byte_vld && byte_sof) && !frm_end
      |=> addr_ready && $stable(match_status) && $stable(accept));

  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_valid) && ($past(frm_len) < LEN_W'(MIN_LEN) || $past(frm_len) > LEN_W'(MAX_LEN))
      |-> !accept);

  assert_jumbo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_valid) && $past(frm_len) > LEN_W'(JUMBO_LEN) && !$past(cfg_jumbo) |-> !accept);

  assert_big_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_valid) && $past(frm_len) > LEN_W'(BIG_LEN) && !$past(cfg_big) |-> !accept);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ready && !verdict_valid |-> !accept && match_status == 32'd0);
endmodule

bind dest_addr_filter dest_addr_filter_chk #(
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN),
  .JUMBO_LEN(JUMBO_LEN), .BIG_LEN(BIG_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
  .frm_end(frm_end), .frm_len(frm_len), .cfg_no_bcast(cfg_no_bcast),
  .cfg_copy_all(cfg_copy_all), .cfg_jumbo(cfg_jumbo), .cfg_big(cfg_big),
  .addr_ready(addr_ready), .verdict_valid(verdict_valid), .accept(accept),
  .match_status(match_status)
);

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        byte_vld = 1'b0, byte_sof = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        frm_end = 1'b0;
  logic [13:0] frm_len = '0;
  logic        cfg_no_bcast = 1'b0, cfg_copy_all = 1'b0, cfg_jumbo = 1'b0, cfg_big = 1'b0;
  logic        addr_ready, verdict_valid, accept;
  logic [31:0] match_status;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dest_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_data(byte_data),
    .frm_end(frm_end), .frm_len(frm_len), .cfg_no_bcast(cfg_no_bcast),
    .cfg_copy_all(cfg_copy_all), .cfg_jumbo(cfg_jumbo), .cfg_big(cfg_big),
    .addr_ready(addr_ready), .verdict_valid(verdict_valid), .accept(accept),
    .match_status(match_status)
  );

  localparam logic [31:0] B26 = 32'h0400_0000, B25 = 32'h0200_0000,
                          B24 = 32'h0100_0000, B23 = 32'h0080_0000, B31 = 32'h8000_0000;
  localparam logic [47:0] DA_A = 48'h0203_0405_0607, DA_B = 48'h00aa_bbcc_ddee,
                          DA_F = 48'hffff_ffff_ffff;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_lo(int s, logic [31:0] v);
    reg_we = 1'b1; reg_sel = {2'(s), 1'b0}; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic write_hi(int s, logic [15:0] v);
    reg_we = 1'b1; reg_sel = {2'(s), 1'b1}; reg_wdata = {16'h0, v};
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic write_slot(int s, logic [47:0] da);
    write_lo(s, da[47:16]);
    write_hi(s, da[15:0]);
  endtask

  task automatic send_da(logic [47:0] da, int n);
    for (int k = 0; k < n; k++) begin
      byte_vld = 1'b1; byte_sof = (k == 0); byte_data = da[47 - 8*k -: 8];
      @(negedge clk);
    end
    byte_vld = 1'b0; byte_sof = 1'b0;
  endtask

  task automatic end_frame(int len);
    frm_len = 14'(len); frm_end = 1'b1;
    @(negedge clk); frm_end = 1'b0;
  endtask

  task automatic expect_addr(string tag, logic [47:0] da, logic acc, logic [31:0] st);
    send_da(da, 6);
    check({tag, " ready"}, 32'(addr_ready), 32'd1);
    check({tag, " accept"}, 32'(accept), 32'(acc));
    check({tag, " status"}, match_status, st);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; repeat (3) @(negedge clk);
    check("R1 ready", 32'(addr_ready), 32'd0);
    check("R1 verdict", 32'(verdict_valid), 32'd0);
    check("R1 accept", 32'(accept), 32'd0);
    check("R1 status", match_status, 32'd0);
    rst_n = 1'b1; @(negedge clk);
    expect_addr("R1 zero addr, slots idle", 48'h0, 1'b0, 32'd0);
  endtask

  task automatic t_byte_order;
    write_slot(0, DA_A);
    expect_addr("R2 slot0 match", DA_A, 1'b1, B26);
    expect_addr("R2 reversed bytes", 48'h0706_0504_0302, 1'b0, 32'd0);
    expect_addr("R2 swapped halves", 48'h0607_0203_0405, 1'b0, 32'd0);
  endtask

  task automatic t_priority;
    write_slot(0, 48'h1111_1111_1111);
    write_slot(1, DA_B); write_slot(2, DA_B); write_slot(3, DA_B);
    expect_addr("R4 slot1 over 2,3", DA_B, 1'b1, B25);
    write_lo(1, DA_B[47:16]);
    expect_addr("R3 slot1 off by low write", DA_B, 1'b1, B24);
    write_lo(2, DA_B[47:16]);
    expect_addr("R3 slot2 off", DA_B, 1'b1, B23);
    write_lo(3, DA_B[47:16]);
    expect_addr("R3 all off", DA_B, 1'b0, 32'd0);
    write_hi(3, DA_B[15:0]);
    expect_addr("R3 slot3 on by high write", DA_B, 1'b1, B23);
    expect_addr("R4 slot0 bit", 48'h1111_1111_1111, 1'b1, B26);
  endtask

  task automatic t_bcast;
    cfg_no_bcast = 1'b0;
    expect_addr("R5 broadcast on", DA_F, 1'b1, B31);
    cfg_no_bcast = 1'b1;
    expect_addr("R5 broadcast off", DA_F, 1'b0, 32'd0);
    write_slot(2, DA_F);
    expect_addr("R5 slot beats bcast disable", DA_F, 1'b1, B24);
    cfg_no_bcast = 1'b0;
    expect_addr("R5 slot precedes bcast", DA_F, 1'b1, B24);
    write_lo(2, 32'h0);
  endtask

  task automatic t_copy_all;
    cfg_copy_all = 1'b1;
    expect_addr("R6 copy all", 48'h5555_6666_7777, 1'b1, 32'd0);
    cfg_copy_all = 1'b0;
    expect_addr("R6 no copy", 48'h5555_6666_7777, 1'b0, 32'd0);
  endtask

  task automatic len_case(string tag, int len, logic j, logic b, logic exp);
    cfg_jumbo = j; cfg_big = b;
    send_da(DA_F, 6);
    end_frame(len);
    check({tag, " verdict"}, 32'(verdict_valid), 32'd1);
    check({tag, " accept"}, 32'(accept), 32'(exp));
  endtask

  task automatic t_length;
    len_case("R8 len 64", 64, 1'b0, 1'b0, 1'b1);
    len_case("R8 len 5", 5, 1'b1, 1'b1, 1'b0);
    len_case("R8 len 10240", 10240, 1'b1, 1'b1, 1'b1);
    len_case("R8 len 10241", 10241, 1'b1, 1'b1, 1'b0);
    len_case("R9 1537 no jumbo", 1537, 1'b0, 1'b1, 1'b0);
    len_case("R9 1536 no jumbo", 1536, 1'b0, 1'b1, 1'b1);
    len_case("R9 1519 no big", 1519, 1'b1, 1'b0, 1'b0);
    len_case("R9 1518 no big", 1518, 1'b0, 1'b0, 1'b1);
    cfg_jumbo = 1'b0; cfg_big = 1'b0;
    send_da(48'h5555_6666_7777, 6);
    end_frame(64);
    check("R11 unmatched verdict", 32'(accept), 32'd0);
  endtask

  task automatic t_short;
    send_da(DA_F, 3);
    check("R10 no decision", 32'(addr_ready), 32'd0);
    check("R11 no decision accept", 32'(accept), 32'd0);
    end_frame(100);
    check("R10 verdict", 32'(verdict_valid), 32'd1);
    check("R10 reject", 32'(accept), 32'd0);
  endtask

  task automatic t_hold;
    expect_addr("R7 decide", DA_B, 1'b1, B23);
    repeat (3) @(negedge clk);
    check("R7 held ready", 32'(addr_ready), 32'd1);
    check("R7 held status", match_status, B23);
    check("R7 held accept", 32'(accept), 32'd1);
    end_frame(64);
    repeat (3) @(negedge clk);
    check("R7 verdict held", 32'(verdict_valid), 32'd1);
    check("R7 status kept", match_status, B23);
    send_da(DA_B, 1);
    check("R7 sof clears ready", 32'(addr_ready), 32'd0);
    check("R7 sof clears verdict", 32'(verdict_valid), 32'd0);
    check("R7 sof clears status", match_status, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_byte_order;
    t_priority;
    t_bcast;
    t_copy_all;
    t_length;
    t_short;
    t_hold;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule